// File: doc/BRIEF.md
# Selectable Exposure Timer

This block sets the length of the integrate period in an image sensor frame sequencer. A start pulse opens an exposure. In internal mode the exposure lasts a whole number of 10 ms units, counted as rising edges of a 100 Hz unit clock. A 5-bit code picks that number from a fixed, non-linear table of 32 entries. In external mode the exposure ends instead on the rising edge of a user control line. When the exposure ends, the block issues a one-cycle done pulse back to the sequencer.

In internal mode the exposure does not begin at the start pulse. It begins on the first unit clock edge that follows it, so that every exposure with the same code lasts the same time. The unit clock and the user line are asynchronous to the system clock, so each passes through a synchroniser before its edges are used. A strap input can switch off the sensor output amplifier for the length of the exposure. All three selections are captured at the start pulse.

Top module: `exposure_timer`

## Requirements
- R1: While reset is asserted and after its release, `integrating_o` and `done_o` are 0 and `amp_en_o` is 1, until the first start pulse.
- R2: In internal mode, code c (0..31) selects U(c) units. U(c)=c for c 0..10. U(c)=10*(c-9) for c 11..19. U(c)=100*(c-18) for c 20..28. Codes 29, 30 and 31 give 3500, 5000 and 6500 units.
- R3: In internal mode with U(c)>0, `integrating_o` rises after the first synchronised unit clock rising edge that follows the start pulse. It stays high for exactly U(c) unit clock periods.
- R4: In internal mode with code 0, `done_o` is high in the cycle right after the start pulse is sampled, and `integrating_o` never rises.
- R5: `done_o` is a single-cycle pulse. When an exposure ends, it is high in the first cycle in which `integrating_o` is low again.
- R6: In external mode, `integrating_o` is high in the cycle after the start pulse. It falls, together with a done pulse, within 2 to 4 cycles of a rising edge on `user_end_i`. Unit clock edges do not end it.
- R7: If `amp_off_i` is 1 at the start pulse, `amp_en_o` is 0 exactly while `integrating_o` is 1. If it is 0, `amp_en_o` stays 1.
- R8: The code, the mode and the amplifier strap are sampled only at an accepted start pulse. A start pulse that arrives while an exposure is pending or running is ignored, and changing the inputs during a run does not change its length.
- R9: Only rising edges of `user_end_i` act. A user line that is already high when an external exposure starts does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an exposure |
| code_i | input | 5 | Exposure length code for internal mode |
| ext_mode_i | input | 1 | 1 = the user line ends the exposure, 0 = the table sets its length |
| amp_off_i | input | 1 | 1 = switch the output amplifier off during exposure |
| unit_clk_i | input | 1 | Asynchronous 100 Hz unit time clock |
| user_end_i | input | 1 | Asynchronous user line; its rising edge ends an external exposure |
| integrating_o | output | 1 | High while the exposure runs |
| done_o | output | 1 | One-cycle pulse at the end of an exposure |
| amp_en_o | output | 1 | Output amplifier supply enable |

## Verification
A wrong unit count or a wrong table entry shows up as an exposure length that is off by a whole number of unit periods. This appears at the falling edge of `integrating_o`, so the bench measures every run to the exact cycle. A control state stuck in the wait or run phase shows up as a missing done pulse, or as an `amp_en_o` that stays low. Either fault appears within one unit period of the expected end. A selection that is not held constant during a run appears as a wrong length in the run where the inputs were changed.

// File: rtl/exp_timer_pkg.sv
package exp_timer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_RUN   = 2'd2
   } exp_state_t;

   localparam int MAX_UNITS = 6500;

   // piecewise exposure table, in units of the slow clock
   function automatic int unsigned units_for_code(input logic [4:0] c);
      int unsigned v;
      v = int'(c);
      if (v <= 10)       return v;
      else if (v <= 19)  return (v - 9) * 10;
      else if (v <= 28)  return (v - 18) * 100;
      else if (v == 29)  return 3500;
      else if (v == 30)  return 5000;
      else               return 6500;
   endfunction

endpackage

// File: rtl/exp_sync_rise.sv
module exp_sync_rise #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("exp_sync_rise: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   // R9: an edge event lasts a single cycle
   p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/exp_unit_lut.sv
module exp_unit_lut
   import exp_timer_pkg::*;
#(
   parameter int CODE_W = 5,
   parameter int CNT_W  = 13
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  units_o
);
   if (CODE_W != 5) begin : g_bad_code
      $error("exp_unit_lut: table is defined for a 5-bit code");
   end
   if ((1 << CNT_W) <= MAX_UNITS) begin : g_bad_cnt
      $error("exp_unit_lut: CNT_W too narrow for the longest exposure");
   end

   always_comb begin
      units_o = CNT_W'(units_for_code(code_i[4:0]));
   end

   // R2: table never exceeds its longest entry
   always_comb begin
      a_lut_bound_r2: assert (int'(units_o) <= MAX_UNITS);
   end

endmodule

// File: rtl/exp_seq_ctl.sv
module exp_seq_ctl
   import exp_timer_pkg::*;
#(
   parameter int CODE_W = 5,
   parameter int CNT_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              ext_mode_i,
   input  logic              amp_off_i,
   input  logic              unit_rise_i,
   input  logic              user_rise_i,
   output logic              running_o,
   output logic              done_o,
   output logic              amp_off_o
);
   exp_state_t        state_q;
   logic [CODE_W-1:0] code_q;
   logic              ext_q;
   logic              amp_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  target;
   logic [CODE_W-1:0] code_sel;
   logic              accept;

   assign accept   = start_i && (state_q == ST_IDLE);
   assign code_sel = (state_q == ST_IDLE) ? code_i : code_q;

   exp_unit_lut #(.CODE_W(CODE_W), .CNT_W(CNT_W)) lut_i (
      .code_i  (code_sel),
      .units_o (target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         ext_q   <= 1'b0;
         amp_q   <= 1'b0;
         cnt_q   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  code_q <= code_i;
                  ext_q  <= ext_mode_i;
                  amp_q  <= amp_off_i;
                  cnt_q  <= '0;
                  if (ext_mode_i)          state_q <= ST_RUN;
                  else if (target == '0)   done_o  <= 1'b1;
                  else                     state_q <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               if (unit_rise_i) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (ext_q) begin
                  if (user_rise_i) begin
                     state_q <= ST_IDLE;
                     done_o  <= 1'b1;
                  end
               end else if (unit_rise_i) begin
                  if (cnt_q + 1'b1 == target) begin
                     state_q <= ST_IDLE;
                     done_o  <= 1'b1;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign running_o = (state_q == ST_RUN);
   assign amp_off_o = amp_q;

   // R2: the unit count stays below the selected length
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !ext_q) |-> (cnt_q < target));
   // R8: captured selections stay put while busy
   p_hold_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !accept) |=> $stable(code_q) && $stable(ext_q) && $stable(amp_q));
   // R5: done is a lone pulse
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/exposure_timer.sv
module exposure_timer
   import exp_timer_pkg::*;
#(
   parameter int CODE_W      = 5,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(MAX_UNITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              ext_mode_i,
   input  logic              amp_off_i,
   input  logic              unit_clk_i,
   input  logic              user_end_i,
   output logic              integrating_o,
   output logic              done_o,
   output logic              amp_en_o
);
   logic unit_rise;
   logic user_rise;
   logic amp_off;

   exp_sync_rise #(.STAGES(SYNC_STAGES)) unit_sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (unit_clk_i),
      .rise_o  (unit_rise)
   );

   exp_sync_rise #(.STAGES(SYNC_STAGES)) user_sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (user_end_i),
      .rise_o  (user_rise)
   );

   exp_seq_ctl #(.CODE_W(CODE_W), .CNT_W(CNT_W)) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .code_i      (code_i),
      .ext_mode_i  (ext_mode_i),
      .amp_off_i   (amp_off_i),
      .unit_rise_i (unit_rise),
      .user_rise_i (user_rise),
      .running_o   (integrating_o),
      .done_o      (done_o),
      .amp_off_o   (amp_off)
   );

   assign amp_en_o = ~(integrating_o & amp_off);

   // R7: amplifier is only ever cut while exposing
   p_amp_idle_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !integrating_o |-> amp_en_o);
   // R5: done never overlaps the exposure
   p_done_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !integrating_o);
   // R5: every exposure end produces a done pulse
   p_end_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(integrating_o) |-> done_o);

endmodule

// File: tb/exposure_timer_tb_top.sv
module exposure_timer_tb_top;
   localparam int UP = 8;  // unit clock period in system cycles

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [4:0] code_i = '0;
   logic       ext_mode_i = 1'b0;
   logic       amp_off_i = 1'b0;
   logic       unit_clk_i = 1'b0;
   logic       user_end_i = 1'b0;
   logic       integrating_o, done_o, amp_en_o;

   int n_tests = 0;
   int n_fail  = 0;
   int ph      = 0;
   bit unit_run = 1'b0;

   always #5 clk = ~clk;

   exposure_timer dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
      .ext_mode_i(ext_mode_i), .amp_off_i(amp_off_i), .unit_clk_i(unit_clk_i),
      .user_end_i(user_end_i), .integrating_o(integrating_o), .done_o(done_o),
      .amp_en_o(amp_en_o)
   );

   // unit clock: low for phases 0..3, high for 4..7
   initial begin
      forever begin
         @(negedge clk);
         if (unit_run) begin
            ph = (ph + 1) % UP;
            unit_clk_i = (ph >= UP/2);
         end
      end
   end

   function automatic int exp_units(input int c);
      int ms;
      if (c <= 10)      ms = c * 10;
      else if (c < 20)  ms = 200 + (c - 11) * 100;
      else if (c < 29)  ms = 2000 + (c - 20) * 1000;
      else if (c == 29) ms = 35000;
      else if (c == 30) ms = 50000;
      else              ms = 65000;
      return ms / 10;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wait_low_phase();
      do @(negedge clk); while (ph != 1);
   endtask

   task automatic pulse_start(input int c, input bit ext, input bit amp);
      code_i = 5'(c); ext_mode_i = ext; amp_off_i = amp; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // internal run; optional disturbing start mid-run
   task automatic run_internal(input int c, input bit amp, input bit disturb);
      int len = 0;
      int guard = 0;
      bit amp_ok = 1'b1;
      int expu = exp_units(c);
      wait_low_phase();
      pulse_start(c, 1'b0, amp);
      if (expu == 0) begin
         check(done_o == 1'b1, "R4 done after code 0", int'(done_o), 1);
         check(integrating_o == 1'b0, "R4 no exposure on code 0", int'(integrating_o), 0);
         @(negedge clk);
         check(done_o == 1'b0 && integrating_o == 1'b0, "R4 R5 quiet after code 0",
               int'(done_o), 0);
         return;
      end
      while (!integrating_o && guard < 3*UP) begin
         check(done_o == 1'b0, "R3 no done while aligning", int'(done_o), 0);
         @(negedge clk); guard++;
      end
      check(integrating_o == 1'b1, "R3 exposure began after unit edge", int'(integrating_o), 1);
      while (integrating_o) begin
         if (amp_en_o != !amp) amp_ok = 1'b0;
         if (disturb && len == 3) begin
            code_i = 5'd31; ext_mode_i = 1'b1; amp_off_i = ~amp; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         len++;
         @(negedge clk);
      end
      start_i = 1'b0;
      check(len == expu * UP, disturb ? "R8 length unchanged by busy start" :
            "R2 R3 exposure length", len, expu * UP);
      check(amp_ok, "R7 amplifier enable during exposure", int'(amp_ok), 1);
      check(done_o == 1'b1, "R5 done at exposure end", int'(done_o), 1);
      check(amp_en_o == 1'b1, "R7 amplifier back on", int'(amp_en_o), 1);
      @(negedge clk);
      check(done_o == 1'b0, "R5 done single cycle", int'(done_o), 0);
   endtask

   task automatic run_external(input bit pre_high, input bit amp);
      int lat = 0;
      user_end_i = pre_high;
      repeat (6) @(negedge clk);
      pulse_start(7, 1'b1, amp);
      check(integrating_o == 1'b1, "R6 exposure starts on start pulse", int'(integrating_o), 1);
      repeat (5*UP) @(negedge clk);
      check(integrating_o == 1'b1 && done_o == 1'b0,
            pre_high ? "R9 held-high user line ignored" : "R6 unit edges ignored",
            int'(integrating_o), 1);
      check(amp_en_o == !amp, "R7 amplifier in external mode", int'(amp_en_o), int'(!amp));
      if (pre_high) begin
         user_end_i = 1'b0;
         repeat (5) @(negedge clk);
         check(integrating_o == 1'b1, "R9 falling user edge ignored", int'(integrating_o), 1);
      end
      user_end_i = 1'b1;
      while (integrating_o && lat < 10) begin @(negedge clk); lat++; end
      check(lat >= 2 && lat <= 4, "R6 end latency after user edge", lat, 3);
      check(done_o == 1'b1, "R6 done on user edge", int'(done_o), 1);
      @(negedge clk);
      user_end_i = 1'b0;
   endtask

   initial begin
      int seed = 32'h5eed_0042;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check(integrating_o == 1'b0 && done_o == 1'b0 && amp_en_o == 1'b1,
            "R1 outputs in reset", int'(integrating_o), 0);
      rst_n = 1'b1;
      unit_run = 1'b1;
      repeat (20) @(negedge clk);
      check(integrating_o == 1'b0 && done_o == 1'b0 && amp_en_o == 1'b1,
            "R1 idle after reset", int'(integrating_o), 0);

      run_internal(0, 1'b1, 1'b0);
      run_internal(1, 1'b1, 1'b0);
      run_internal(10, 1'b0, 1'b0);
      run_internal(11, 1'b1, 1'b0);
      run_internal(19, 1'b0, 1'b0);
      run_internal(20, 1'b1, 1'b0);
      run_internal(3, 1'b1, 1'b1);
      run_external(1'b0, 1'b1);
      run_external(1'b1, 1'b0);
      for (int k = 0; k < 20; k++) begin
         int c = int'($urandom_range(0, 20));
         bit a = 1'($urandom_range(0, 1));
         run_internal(c, a, 1'($urandom_range(0, 3) == 0));
      end
      run_internal(28, 1'b0, 1'b0);
      run_internal(29, 1'b1, 1'b0);
      run_internal(31, 1'b1, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule